// File: doc/BRIEF.md
# Masked Interrupt Controller with Fast-Line Steering

This block gathers level-sensitive interrupt requests from up to 64 on-chip sources and drives two processor interrupt lines: a normal interrupt line and a fast interrupt line. Each source has an enable bit and a steering bit. A source raises the line chosen by its steering bit only while it is requesting and enabled. The sources are split into a low bank (sources 0 to 31) and a high bank (sources 32 to 63). Each bank has its own enable and steering words.

A separate wake output tells the power controller that the processor should leave idle. A control bit sets its behaviour. When the bit is clear, any raw request wakes the system, whether enabled or not. When it is set, only enabled requests wake it. Requests are not latched. A source stays pending until the peripheral that raised it drops its request. Software silences a source in the meantime by clearing its enable bit.

Software reaches the block through a simple word-addressed register bus with separate read and write strobes. Reads return data one cycle after the strobe.

Top module: `lvl_intc`

## Requirements
- R1: After reset, every enable bit, steering bit and the wake-control bit are 0, and all three outputs are low. Every register address reads 0 while no source is requesting.
- R2: A source counts as pending only while its request input is 1 and its enable bit is 1. The pending word for a bank reads as the request inputs ANDed with that bank's enable word.
- R3: The normal line is the OR of pending sources whose steering bit is 0. The fast line is the OR of pending sources whose steering bit is 1.
- R4: Source n for n ≥ 32 is controlled and reported by bit n−32 of the high-bank words. Source n below 32 uses bit n of the low-bank words.
- R5: With wake-control bit 0 of address 6 set to 1, wake_o is the OR of pending sources. With it at 0, wake_o is the OR of all raw request inputs.
- R6: Requests are level-sensitive. An output stays high while its request is held and falls one clock after the request input drops.
- R7: Clearing a source's enable bit while its request is held removes it from both lines and from the pending word.
- R8: A write takes effect at the clock edge that samples it. The outputs are registered: they reflect inputs and registers one clock later. Read data appears in the cycle after the read strobe and holds until the next read.
- R9: The register map is fixed: 0 low pending (read-only), 1 high pending (read-only), 2 low enable, 3 high enable, 4 low steering, 5 high steering, 6 control (bit 0 only). Writes to 0, 1 and 7 change nothing, and address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Level request from each source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt line |
| fast_irq_o | output | 1 | Fast interrupt line |
| wake_o | output | 1 | Idle wake request |

## Verification
The hardest case to reach is a source that is requesting but disabled, or a source in the high bank steered opposite to an enabled low-bank source. In that state the two lines and the wake output must all disagree with a simple OR of the inputs. A table of vectors programs all five control words before each step. This places raw-but-masked, masked-but-steered and mixed-bank requests side by side, with the wake-control bit in both states. Directed tests then hold a request while its enable is cleared, and count edges to pin the single cycle in which each output falls.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;
   localparam int BANK_W   = 32;
   localparam int MAX_BANK = 2;
   localparam int MAP_W    = 3;

   typedef enum logic [MAP_W-1:0] {
      RA_PEND_LO = 3'd0,
      RA_PEND_HI = 3'd1,
      RA_EN_LO   = 3'd2,
      RA_EN_HI   = 3'd3,
      RA_RT_LO   = 3'd4,
      RA_RT_HI   = 3'd5,
      RA_CTRL    = 3'd6,
      RA_NONE    = 3'd7
   } reg_addr_e;

   function automatic logic [BANK_W-1:0] live_mask(input int width);
      logic [BANK_W-1:0] m;
      m = '0;
      for (int i = 0; i < BANK_W; i++)
         if (i < width) m[i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/lvl_intc_bank.sv
module lvl_intc_bank
   import lvl_intc_pkg::*;
#(
   parameter int LIVE = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_we,
   input  logic              rt_we,
   input  logic [BANK_W-1:0] wdata,
   input  logic [BANK_W-1:0] src,
   output logic [BANK_W-1:0] en_q,
   output logic [BANK_W-1:0] rt_q,
   output logic [BANK_W-1:0] pend
);
   localparam logic [BANK_W-1:0] LIVE_M = live_mask(LIVE);

   if (LIVE < 1 || LIVE > BANK_W) begin : g_bad_live
      $error("lvl_intc_bank: LIVE out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
         rt_q <= '0;
      end else begin
         if (en_we) en_q <= wdata & LIVE_M;
         if (rt_we) rt_q <= wdata & LIVE_M;
      end
   end

   assign pend = src & en_q & LIVE_M;

   // R8
   en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_we |=> en_q == ($past(wdata) & LIVE_M));

   // R7
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_we && wdata == '0) |=> pend == '0);
endmodule

// File: rtl/lvl_intc_regs.sv
module lvl_intc_regs
   import lvl_intc_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BANK_W-1:0] bus_wdata,
   input  logic [BANK_W-1:0] pend_lo,
   input  logic [BANK_W-1:0] pend_hi,
   input  logic [BANK_W-1:0] en_lo,
   input  logic [BANK_W-1:0] en_hi,
   input  logic [BANK_W-1:0] rt_lo,
   input  logic [BANK_W-1:0] rt_hi,
   output logic              we_en_lo,
   output logic              we_en_hi,
   output logic              we_rt_lo,
   output logic              we_rt_hi,
   output logic              wake_only_en,
   output logic [BANK_W-1:0] bus_rdata
);
   if (ADDR_W < MAP_W) begin : g_bad_addr
      $error("lvl_intc_regs: ADDR_W too small for register map");
   end

   logic      in_range;
   reg_addr_e sel;
   logic      we_ctrl;
   logic [BANK_W-1:0] rd_mux;

   if (ADDR_W > MAP_W) begin : g_wide_addr
      assign in_range = (bus_addr[ADDR_W-1:MAP_W] == '0);
   end else begin : g_exact_addr
      assign in_range = 1'b1;
   end

   assign sel      = reg_addr_e'(bus_addr[MAP_W-1:0]);
   assign we_en_lo = bus_wr && in_range && sel == RA_EN_LO;
   assign we_en_hi = bus_wr && in_range && sel == RA_EN_HI;
   assign we_rt_lo = bus_wr && in_range && sel == RA_RT_LO;
   assign we_rt_hi = bus_wr && in_range && sel == RA_RT_HI;
   assign we_ctrl  = bus_wr && in_range && sel == RA_CTRL;

   always_comb begin
      rd_mux = '0;
      if (in_range) begin
         unique case (sel)
            RA_PEND_LO: rd_mux = pend_lo;
            RA_PEND_HI: rd_mux = pend_hi;
            RA_EN_LO:   rd_mux = en_lo;
            RA_EN_HI:   rd_mux = en_hi;
            RA_RT_LO:   rd_mux = rt_lo;
            RA_RT_HI:   rd_mux = rt_hi;
            RA_CTRL:    rd_mux = {{(BANK_W-1){1'b0}}, wake_only_en};
            default:    rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_only_en <= 1'b0;
         bus_rdata    <= '0;
      end else begin
         if (we_ctrl) wake_only_en <= bus_wdata[0];
         if (bus_rd)  bus_rdata    <= rd_mux;
      end
   end

   // R9
   ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && in_range && sel == RA_CTRL) |=>
         bus_rdata == {{(BANK_W-1){1'b0}}, $past(wake_only_en)});

   // R8
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   // R9
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({we_en_lo, we_en_hi, we_rt_lo, we_rt_hi, we_ctrl}));
endmodule

// File: rtl/lvl_intc_out.sv
module lvl_intc_out #(
   parameter int N = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src,
   input  logic [N-1:0] pend,
   input  logic [N-1:0] steer,
   input  logic         wake_only_en,
   output logic         irq_q,
   output logic         fast_q,
   output logic         wake_q
);
   logic norm_any, fast_any, wake_any;

   assign norm_any = |(pend & ~steer);
   assign fast_any = |(pend & steer);
   assign wake_any = wake_only_en ? |pend : |src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         fast_q <= 1'b0;
         wake_q <= 1'b0;
      end else begin
         irq_q  <= norm_any;
         fast_q <= fast_any;
         wake_q <= wake_any;
      end
   end

   // R3
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(|pend));

   // R5
   wake_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_only_en && pend == '0) |=> !wake_q);

   // R6
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src == '0) |=> (!irq_q && !fast_q && !wake_q));

   // R2
   pend_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & ~src) == '0);
endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
   import lvl_intc_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int ADDR_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               irq_o,
   output logic               fast_irq_o,
   output logic               wake_o
);
   localparam int NBANK = (NUM_SRC + BANK_W - 1) / BANK_W;
   localparam int FULL  = MAX_BANK * BANK_W;

   if (NUM_SRC < 1 || NUM_SRC > FULL) begin : g_bad_src
      $error("lvl_intc: NUM_SRC must lie in 1..64");
   end

   logic [FULL-1:0]   src_pad;
   logic [BANK_W-1:0] en_w   [MAX_BANK];
   logic [BANK_W-1:0] rt_w   [MAX_BANK];
   logic [BANK_W-1:0] pend_w [MAX_BANK];
   logic [MAX_BANK-1:0] we_en, we_rt;
   logic wake_only_en;

   assign src_pad = FULL'(src_i);

   for (genvar b = 0; b < MAX_BANK; b++) begin : g_bank
      if (b < NBANK) begin : g_live
         localparam int W = (b == NBANK - 1) ? (NUM_SRC - b * BANK_W) : BANK_W;
         lvl_intc_bank #(.LIVE(W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .en_we (we_en[b]),
            .rt_we (we_rt[b]),
            .wdata (bus_wdata),
            .src   (src_pad[b*BANK_W +: BANK_W]),
            .en_q  (en_w[b]),
            .rt_q  (rt_w[b]),
            .pend  (pend_w[b])
         );
      end else begin : g_absent
         assign en_w[b]   = '0;
         assign rt_w[b]   = '0;
         assign pend_w[b] = '0;
      end
   end

   lvl_intc_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_wr       (bus_wr),
      .bus_rd       (bus_rd),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .pend_lo      (pend_w[0]),
      .pend_hi      (pend_w[1]),
      .en_lo        (en_w[0]),
      .en_hi        (en_w[1]),
      .rt_lo        (rt_w[0]),
      .rt_hi        (rt_w[1]),
      .we_en_lo     (we_en[0]),
      .we_en_hi     (we_en[1]),
      .we_rt_lo     (we_rt[0]),
      .we_rt_hi     (we_rt[1]),
      .wake_only_en (wake_only_en),
      .bus_rdata    (bus_rdata)
   );

   lvl_intc_out #(.N(FULL)) u_out (
      .clk          (clk),
      .rst_n        (rst_n),
      .src          (src_pad),
      .pend         ({pend_w[1], pend_w[0]}),
      .steer        ({rt_w[1], rt_w[0]}),
      .wake_only_en (wake_only_en),
      .irq_q        (irq_o),
      .fast_q       (fast_irq_o),
      .wake_q       (wake_o)
   );

   // R4
   hi_bank_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_w[1] != '0 && pend_w[0] == '0 && (pend_w[1] & rt_w[1]) == '0) |=>
         (irq_o && !fast_irq_o));
endmodule

// File: tb/lvl_intc_test.sv
`timescale 1ns/1ps
module lvl_intc_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] src = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o, fast_irq_o, wake_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   lvl_intc uut (
      .clk(clk), .rst_n(rst_n), .src_i(src),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .fast_irq_o(fast_irq_o), .wake_o(wake_o)
   );

   typedef struct packed {
      logic [63:0] src;
      logic [63:0] en;
      logic [63:0] rt;
      logic        ctl;
      logic        x_irq;
      logic        x_fast;
      logic        x_wake;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 64'h0, 1'b0, 1'b1, 1'b0, 1'b1},
      '{64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 64'h1, 1'b1, 1'b0, 1'b1, 1'b1},
      '{64'h0000_0000_0000_0001, 64'h0, 64'h0, 1'b1, 1'b0, 1'b0, 1'b0},
      '{64'h0000_0000_0000_0001, 64'h0, 64'h0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, 64'h0, 1'b1, 1'b1, 1'b0, 1'b1},
      '{64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1, 1'b0, 1'b1, 1'b1},
      '{64'h8000_0000_0000_0002, 64'h0000_0000_0000_0002, 64'h8000_0000_0000_0000, 1'b1, 1'b1, 1'b0, 1'b1},
      '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, 1'b0, 1'b0, 1'b0},
      '{64'h0F0F_0000_0000_F0F0, 64'h0000_FFFF_FFFF_0000, 64'h0, 1'b1, 1'b0, 1'b0, 1'b0},
      '{64'h00FF_00FF_00FF_00FF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b1}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [63:0] pexp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", irq_o, 0);
      chk("R1 fast", fast_irq_o, 0);
      chk("R1 wake", wake_o, 0);
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), d);
         chk("R1 reg", d, 0);
      end

      // R2 R3 R4 R5 table walk
      for (int i = 0; i < NV; i++) begin
         wr(3'd2, VEC[i].en[31:0]);
         wr(3'd3, VEC[i].en[63:32]);
         wr(3'd4, VEC[i].rt[31:0]);
         wr(3'd5, VEC[i].rt[63:32]);
         wr(3'd6, {31'b0, VEC[i].ctl});
         src = VEC[i].src;
         @(negedge clk);
         chk("R3 irq", irq_o, VEC[i].x_irq);
         chk("R3 fast", fast_irq_o, VEC[i].x_fast);
         chk("R5 wake", wake_o, VEC[i].x_wake);
         pexp = VEC[i].src & VEC[i].en;
         rd(3'd0, d);
         chk("R2 pend lo", d, pexp[31:0]);
         rd(3'd1, d);
         chk("R4 pend hi", d, pexp[63:32]);
         rd(3'd3, d);
         chk("R4 en hi", d, VEC[i].en[63:32]);
      end

      // R6 level behaviour
      wr(3'd2, 32'h1); wr(3'd3, 0); wr(3'd4, 0); wr(3'd5, 0); wr(3'd6, 1);
      src = 64'h1;
      @(negedge clk);
      chk("R6 held", irq_o, 1);
      @(negedge clk);
      chk("R6 still held", irq_o, 1);
      src = 64'h0;
      @(negedge clk);
      chk("R6 drop", irq_o, 0);
      chk("R6 wake drop", wake_o, 0);

      // R7 acknowledge by disabling, R8 edge count
      src = 64'h1;
      @(negedge clk);
      chk("R7 before", irq_o, 1);
      wr(3'd2, 32'h0);
      chk("R8 one edge later", irq_o, 1);
      @(negedge clk);
      chk("R7 silenced", irq_o, 0);
      rd(3'd0, d);
      chk("R7 pend", d, 0);

      // R9 pending is read-only; address 7 reads zero
      wr(3'd2, 32'h1);
      wr(3'd0, 32'hFFFF_FFFF);
      wr(3'd1, 32'hFFFF_FFFF);
      wr(3'd7, 32'hFFFF_FFFF);
      rd(3'd0, d);
      chk("R9 pend lo ro", d, 32'h1);
      rd(3'd1, d);
      chk("R9 pend hi ro", d, 0);
      rd(3'd7, d);
      chk("R9 addr7", d, 0);
      rd(3'd2, d);
      chk("R9 en lo kept", d, 32'h1);
      rd(3'd6, d);
      chk("R9 ctrl", d, 32'h1);
      chk("R9 irq", irq_o, 1);

      // R8 read data holds without strobe
      @(negedge clk);
      chk("R8 rdata hold", bus_rdata, 32'h1);

      // R1 mid-run reset clears programmed state
      wr(3'd4, 32'h1);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      src = 64'h0;
      rd(3'd2, d); chk("R1 en cleared", d, 0);
      rd(3'd4, d); chk("R1 rt cleared", d, 0);
      rd(3'd6, d); chk("R1 ctrl cleared", d, 0);
      chk("R1 irq after reset", irq_o, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule